// File: doc/BRIEF.md
# Two-Bank Latched Interrupt Controller

This block collects sixteen interrupt request lines into two byte-wide banks, A and B. It presents them to a processor through a small register file. Bank A mostly carries short events such as timer wraps and external pulses. A rising edge on such a line sets a sticky latch, and the latch stays set until software clears it. Lines in bank B, and any bank A line that a parameter marks as level-type, show their input level after one register stage. Software cannot clear these lines.

Each bank has three registers: a status register, a mask register and a request register. The status register reports pending lines whatever the mask. The mask register is readable and writable. The request register is status AND mask. A single active-high `irq` output is raised when any request bit in either bank is set. A further fast-interrupt mask selects bank A status bits onto the `fiq` output. Writing a byte to the bank A request address clears every edge latch whose bit is written as 1.

Top module: `irqc_top`

## Requirements
- R1: Synchronous active-high reset clears all three mask registers, all edge latches and all input registers. After reset, `irq` and `fiq` are 0 and every mask reads 0.
- R2: A 0-to-1 change on an edge-type bank A input sets its status bit at the next clock edge. The bit stays set after the input returns to 0.
- R3: Status registers (address 0x0 for bank A, 0x4 for bank B) report pending bits regardless of the mask contents.
- R4: Request registers (0x1 for bank A, 0x5 for bank B) read status AND mask of their bank. The fast request register (0x9) reads bank A status AND the fast mask.
- R5: `irq` is the OR of all request bits of both banks. `fiq` is the OR of bank A status AND the fast mask. Both follow a mask write from the clock edge that stores it.
- R6: Writing to address 0x1 clears, at that clock edge, each edge latch whose data bit is 1. Latches whose data bit is 0 are left unchanged.
- R7: Level-type lines show their input one clock later. These are all of bank B and bank A bit 7 under the default `EDGE_A` = 0x7F, where 1 marks an edge bit. Writes to 0x1 leave level-type lines unaffected.
- R8: If a new rising edge and a clear of the same bit meet at one clock edge, the bit stays set.
- R9: Masks are written and read back at 0x2 (bank A), 0x6 (bank B) and 0x8 (fast). Reads of any other address return 0, and a mask changes only when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, acts at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| src_a | input | 8 | Bank A request lines (sources 0-7) |
| src_b | input | 8 | Bank B request lines (sources 8-15) |
| irq | output | 1 | Masked interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
Single-cycle pulses on edge lines show whether the latch holds an event after its input has gone idle. Held levels on bank B and on the level-type bank A bit show whether those lines track the input and ignore clear writes. Clears with sparse bit patterns show that only selected bits drop. A clear timed to meet a fresh edge separates edge-wins from clear-wins. Changing masks over fixed pending bits separates status from request and shows which bits drive `irq` and `fiq`.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BANK_W = 8;
    localparam int ADDR_W = 4;

    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STAT_A = 4'h0,
        ADR_REQ_A  = 4'h1,
        ADR_MASK_A = 4'h2,
        ADR_STAT_B = 4'h4,
        ADR_REQ_B  = 4'h5,
        ADR_MASK_B = 4'h6,
        ADR_FMASK  = 4'h8,
        ADR_FREQ   = 4'h9
    } reg_addr_e;

    typedef struct packed {
        bank_t status;
        bank_t mask;
    } bank_view_t;

    function automatic bank_t masked(bank_view_t v);
        return v.status & v.mask;
    endfunction

endpackage

// File: rtl/irqc_src_cell.sv
module irqc_src_cell #(
    parameter bit IS_EDGE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic clr,
    output logic status
);
    logic src_q;

    always_ff @(posedge clk) begin
        if (rst) src_q <= 1'b0;
        else     src_q <= src;
    end

    generate
        if (IS_EDGE) begin : g_edge
            logic hit;
            logic lat;

            assign hit = src & ~src_q;

            always_ff @(posedge clk) begin
                if (rst) lat <= 1'b0;
                else     lat <= (lat & ~clr) | hit;
            end

            assign status = lat;

            a_r2_edge_sets: assert property (@(posedge clk) disable iff (rst)
                hit |=> status);
            a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
                (clr && !hit) |=> !status);
            a_r8_edge_wins: assert property (@(posedge clk) disable iff (rst)
                (clr && hit) |=> status);
        end else begin : g_level
            logic unused_clr;
            assign unused_clr = clr;
            assign status = src_q;
        end
    endgenerate

endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg
    import irqc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  bank_t wdata,
    output bank_t q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata;
    end

    a_r1_mask_reset: assert property (@(posedge clk)
        rst |=> (q == '0));
    a_r9_mask_holds: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter logic [BANK_W-1:0] EDGE_A = 8'h7F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BANK_W-1:0] reg_wdata,
    output logic [BANK_W-1:0] reg_rdata,
    input  logic [BANK_W-1:0] src_a,
    input  logic [BANK_W-1:0] src_b,
    output logic              irq,
    output logic              fiq
);
    bank_t      stat_a, stat_b, mask_a, mask_b, fmask, clr_a;
    bank_view_t view_a, view_b, view_f;
    bank_t      req_a, req_b, req_f;
    logic       we_a, we_b, we_f;

    assign clr_a = (reg_wr && reg_addr == ADR_REQ_A) ? reg_wdata : '0;
    assign we_a  = reg_wr && reg_addr == ADR_MASK_A;
    assign we_b  = reg_wr && reg_addr == ADR_MASK_B;
    assign we_f  = reg_wr && reg_addr == ADR_FMASK;

    generate
        for (genvar i = 0; i < BANK_W; i++) begin : g_bit
            irqc_src_cell #(.IS_EDGE(EDGE_A[i])) u_a (
                .clk(clk), .rst(rst), .src(src_a[i]), .clr(clr_a[i]), .status(stat_a[i])
            );
            irqc_src_cell #(.IS_EDGE(1'b0)) u_b (
                .clk(clk), .rst(rst), .src(src_b[i]), .clr(1'b0), .status(stat_b[i])
            );
        end
    endgenerate

    irqc_mask_reg u_mask_a (.clk(clk), .rst(rst), .we(we_a), .wdata(reg_wdata), .q(mask_a));
    irqc_mask_reg u_mask_b (.clk(clk), .rst(rst), .we(we_b), .wdata(reg_wdata), .q(mask_b));
    irqc_mask_reg u_mask_f (.clk(clk), .rst(rst), .we(we_f), .wdata(reg_wdata), .q(fmask));

    assign view_a = '{status: stat_a, mask: mask_a};
    assign view_b = '{status: stat_b, mask: mask_b};
    assign view_f = '{status: stat_a, mask: fmask};
    assign req_a  = masked(view_a);
    assign req_b  = masked(view_b);
    assign req_f  = masked(view_f);

    assign irq = |{req_a, req_b};
    assign fiq = |req_f;

    always_comb begin
        case (reg_addr_e'(reg_addr))
            ADR_STAT_A: reg_rdata = stat_a;
            ADR_REQ_A:  reg_rdata = req_a;
            ADR_MASK_A: reg_rdata = mask_a;
            ADR_STAT_B: reg_rdata = stat_b;
            ADR_REQ_B:  reg_rdata = req_b;
            ADR_MASK_B: reg_rdata = mask_b;
            ADR_FMASK:  reg_rdata = fmask;
            ADR_FREQ:   reg_rdata = req_f;
            default:    reg_rdata = '0;
        endcase
    end

    a_r5_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        (mask_a == '0 && mask_b == '0) |-> !irq);
    a_r5_fiq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        (fmask == '0) |-> !fiq);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!irq && !fiq));

endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] src_a = 8'h00;
    logic [7:0] src_b = 8'h00;
    logic       irq, fiq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_a(src_a),
        .src_b(src_b), .irq(irq), .fiq(fiq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input string req, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_a(input logic [7:0] bits);
        @(negedge clk);
        src_a = src_a | bits;
        @(negedge clk);
        src_a = src_a & ~bits;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 fiq", {7'd0, fiq}, 8'h00);
        rd(4'h2, "R1 mask_a", 8'h00);
        rd(4'h6, "R1 mask_b", 8'h00);
        rd(4'h8, "R1 fmask", 8'h00);
        rd(4'h0, "R1 stat_a", 8'h00);
    endtask

    task automatic t_edge_latch;
        pulse_a(8'h04);
        rd(4'h0, "R2 latched after pulse", 8'h04);
        repeat (3) @(negedge clk);
        rd(4'h0, "R2 still latched", 8'h04);
    endtask

    task automatic t_mask_request;
        chk("R3 no irq with mask 0", {7'd0, irq}, 8'h00);
        wr(4'h2, 8'h04);
        rd(4'h1, "R4 req_a", 8'h04);
        chk("R5 irq set", {7'd0, irq}, 8'h01);
        rd(4'h2, "R9 mask_a readback", 8'h04);
        wr(4'h2, 8'h01);
        rd(4'h0, "R3 status ignores mask", 8'h04);
        rd(4'h1, "R4 req_a masked off", 8'h00);
        chk("R5 irq clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_level_b;
        @(negedge clk); src_b = 8'h30;
        @(negedge clk);
        rd(4'h4, "R7 stat_b follows", 8'h30);
        chk("R3 irq off, mask_b 0", {7'd0, irq}, 8'h00);
        wr(4'h6, 8'h10);
        rd(4'h5, "R4 req_b", 8'h10);
        chk("R5 irq from bank B", {7'd0, irq}, 8'h01);
        wr(4'h1, 8'hFF);
        rd(4'h4, "R7 bank B ignores clear", 8'h30);
        rd(4'h0, "R6 clear all edges", 8'h00);
        chk("R5 irq stays via B", {7'd0, irq}, 8'h01);
        src_b = 8'h00;
        @(negedge clk);
        rd(4'h4, "R7 stat_b drops", 8'h00);
        chk("R5 irq drops", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_level_a7;
        @(negedge clk); src_a[7] = 1'b1;
        @(negedge clk);
        rd(4'h0, "R7 level bit a7", 8'h80);
        wr(4'h1, 8'h80);
        rd(4'h0, "R7 a7 ignores clear", 8'h80);
        src_a[7] = 1'b0;
        @(negedge clk);
        rd(4'h0, "R7 a7 follows low", 8'h00);
    endtask

    task automatic t_selective_clear;
        pulse_a(8'h03);
        rd(4'h0, "R2 two latches", 8'h03);
        wr(4'h1, 8'h01);
        rd(4'h0, "R6 only bit0 cleared", 8'h02);
    endtask

    task automatic t_collision;
        @(negedge clk);
        src_a[1] = 1'b1;
        reg_addr = 4'h1; reg_wdata = 8'h02; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; src_a[1] = 1'b0;
        rd(4'h0, "R8 edge beats clear", 8'h02);
        wr(4'h1, 8'h02);
        rd(4'h0, "R6 later clear works", 8'h00);
    endtask

    task automatic t_fast;
        pulse_a(8'h08);
        chk("R5 fiq off before fmask", {7'd0, fiq}, 8'h00);
        wr(4'h8, 8'h08);
        chk("R5 fiq on", {7'd0, fiq}, 8'h01);
        chk("R5 irq off (mask_a=01)", {7'd0, irq}, 8'h00);
        rd(4'h9, "R4 fast request", 8'h08);
        wr(4'h1, 8'h08);
        chk("R6 fiq off after clear", {7'd0, fiq}, 8'h00);
    endtask

    task automatic t_unmapped;
        rd(4'h3, "R9 unmapped 3", 8'h00);
        rd(4'hF, "R9 unmapped F", 8'h00);
        rd(4'h6, "R9 mask_b held", 8'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_edge_latch();
        t_mask_request();
        t_level_b();
        t_level_a7();
        t_selective_clear();
        t_collision();
        t_fast();
        t_unmapped();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule